// File: doc/BRIEF.md
# SPI Serial Clock and Frame Timing Generator

This block produces the serial clock and the select-side timing intervals of an SPI master from a single functional clock. When the shift engine raises `start_i` while the block is idle, the block captures a 32-bit command word and a 24-bit timing word. It then runs one frame. The frame begins with a lead interval between chip-select assertion and the first clock edge. Next come one full SCK period per bit. A trailing gap follows before the next frame may start.

All intervals are built on one prescaled time base. The SCK period is the divider plus two, shifted left by the prescaler. The lead and gap intervals are their field plus one, shifted the same way. Alongside SCK the block emits a one-cycle sample strobe and a one-cycle shift strobe for every bit. The phase bit decides which clock edge each strobe belongs to. Two more strobes mark the last cycle of the lead interval and the last cycle of the gap. `busy_o` stays high for the whole frame. The shift engine uses it as the handshake answer to `start_i`.

Top module: `spi_sck_timer`

## Requirements
- R1: SCK period is (cfg_i[7:0] + 2) << cmd_i[29:27] functional-clock cycles. Within each bit, SCK first holds the polarity level and then the opposite level.
- R2: The high phase of a bit lasts period/2 (rounded down) cycles and the low phase takes the rest, so an odd period gives the extra cycle to the low phase. The fastest setting, divider 0 and prescaler 0, gives a 2-cycle period.
- R3: A start accepted at a clock edge makes `busy_o` high in the next cycle. The lead interval then lasts (cfg_i[23:16] + 1) << prescaler cycles, and `lead_done_o` is high only in its last cycle.
- R4: After the last bit, a gap of (cfg_i[15:8] + 1) << prescaler cycles follows with SCK at the polarity level. `gap_done_o` is high only in its last cycle, and `busy_o` falls in the next cycle.
- R5: While no frame is active, SCK sits at the polarity bit cmd_i[31] of the most recently accepted command, or at 0 if none has been accepted since reset.
- R6: With phase bit cmd_i[30] = 0, `sample_o` is high in the last cycle before the leading (first) edge of each bit and `shift_o` in the last cycle before its trailing edge. With phase 1 the two are swapped.
- R7: A frame carries cmd_i[4:0] + 1 bits and therefore gives exactly that many sample strobes and shift strobes.
- R8: `start_i` is ignored while busy, and `cmd_i` and `cfg_i` are used only at the edge where a start is accepted. Changes after that edge do not alter the running frame.
- R9: During and right after reset, `busy_o`, `sck_o` and all four strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one frame, taken only when idle |
| cmd_i | input | 32 | Command: polarity 31, phase 30, prescaler 29:27, bit count minus one 4:0 |
| cfg_i | input | 24 | Timing: divider 7:0, gap 15:8, lead 23:16 |
| busy_o | output | 1 | Frame in progress |
| sck_o | output | 1 | Serial clock |
| sample_o | output | 1 | One-cycle strobe: capture the input bit at the coming edge |
| shift_o | output | 1 | One-cycle strobe: launch the next output bit at the coming edge |
| lead_done_o | output | 1 | Last cycle of the lead interval |
| gap_done_o | output | 1 | Last cycle of the trailing gap |

## Verification
`start_i` is sampled at an edge, and every output belongs to the cycle that follows that edge. `busy_o` and SCK settle at the polarity level one cycle after acceptance. Each strobe is high in the final cycle before the SCK transition it announces. The bench releases `start_i` at the falling edge after acceptance and numbers the cycles from there. At each falling edge it compares all six outputs with a timeline computed from the field values: lead, then bits of one period each, then gap, then idle. After each frame it also compares the strobe totals with the bit count.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_FIRST  = 3'd2,
    ST_SECOND = 3'd3,
    ST_GAP    = 3'd4
  } tim_state_e;

  localparam int CMD_POL_BIT = 31;
  localparam int CMD_PHA_BIT = 30;
  localparam int CMD_PRE_LSB = 27;

endpackage

// File: rtl/spi_tim_len.sv
module spi_tim_len #(
  parameter int DIVW = 8,
  parameter int PREW = 3,
  parameter int CW   = 16
) (
  input  logic [PREW-1:0] pre_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [DIVW-1:0] lead_i,
  input  logic [DIVW-1:0] gap_i,
  input  logic            pol_i,
  output logic [CW-1:0]   lead_len_o,
  output logic [CW-1:0]   gap_len_o,
  output logic [CW-1:0]   first_len_o,
  output logic [CW-1:0]   second_len_o
);

  logic [CW-1:0] per_w;
  logic [CW-1:0] hi_w;
  logic [CW-1:0] lo_w;

  // Every interval is a count of prescaled ticks, widened to functional cycles.
  always_comb begin
    per_w        = (CW'(div_i) + CW'(2)) << pre_i;
    hi_w         = per_w >> 1;
    lo_w         = per_w - hi_w;
    first_len_o  = pol_i ? hi_w : lo_w;
    second_len_o = pol_i ? lo_w : hi_w;
    lead_len_o   = (CW'(lead_i) + CW'(1)) << pre_i;
    gap_len_o    = (CW'(gap_i) + CW'(1)) << pre_i;
  end

endmodule

// File: rtl/spi_tim_cnt.sv
module spi_tim_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (ld_i) begin
      cnt_n = ld_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_tim_out.sv
module spi_tim_out
  import spi_tim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tim_state_e st_q_i,
  input  tim_state_e st_n_i,
  input  logic       pol_n_i,
  input  logic       pha_i,
  input  logic       cyc_zero_i,
  output logic       sck_o,
  output logic       sample_o,
  output logic       shift_o,
  output logic       lead_done_o,
  output logic       gap_done_o
);

  logic sck_q;
  logic sck_n;
  logic lead_edge;
  logic trail_edge;

  // SCK is registered from the next state, so it changes together with the state.
  assign sck_n = pol_n_i ^ (st_n_i == ST_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
    end else begin
      sck_q <= sck_n;
    end
  end

  assign lead_edge   = (st_q_i == ST_FIRST)  && cyc_zero_i;
  assign trail_edge  = (st_q_i == ST_SECOND) && cyc_zero_i;
  assign sample_o    = pha_i ? trail_edge : lead_edge;
  assign shift_o     = pha_i ? lead_edge  : trail_edge;
  assign lead_done_o = (st_q_i == ST_LEAD) && cyc_zero_i;
  assign gap_done_o  = (st_q_i == ST_GAP)  && cyc_zero_i;
  assign sck_o       = sck_q;

endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer
  import spi_tim_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int PREW = 3,
  parameter int LENW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [31:0]         cmd_i,
  input  logic [3*DIVW-1:0]   cfg_i,
  output logic                busy_o,
  output logic                sck_o,
  output logic                sample_o,
  output logic                shift_o,
  output logic                lead_done_o,
  output logic                gap_done_o
);

  localparam int CW = DIVW + 1 + (2**PREW - 1);

  tim_state_e st_q, st_n;

  logic            pol_q, pha_q;
  logic [PREW-1:0] pre_q;
  logic [DIVW-1:0] div_q, lead_q, gap_q;

  logic            acc;
  logic            pol_s;
  logic [PREW-1:0] pre_s;
  logic [DIVW-1:0] div_s, lead_s, gap_s;

  logic [CW-1:0]   lead_len, gap_len, first_len, second_len;
  logic            cyc_ld, cyc_zero;
  logic [CW-1:0]   cyc_val;
  logic            bit_ld, bit_dec, bit_zero;
  logic            unused_cmd;

  assign unused_cmd = ^cmd_i[CMD_PRE_LSB-1:LENW];

  assign acc   = (st_q == ST_IDLE) && start_i;
  assign pol_s = acc ? cmd_i[CMD_POL_BIT] : pol_q;
  assign pre_s = acc ? cmd_i[CMD_PRE_LSB +: PREW] : pre_q;
  assign div_s  = acc ? cfg_i[0 +: DIVW]      : div_q;
  assign gap_s  = acc ? cfg_i[DIVW +: DIVW]   : gap_q;
  assign lead_s = acc ? cfg_i[2*DIVW +: DIVW] : lead_q;

  spi_tim_len #(.DIVW(DIVW), .PREW(PREW), .CW(CW)) u_len (
    .pre_i        (pre_s),
    .div_i        (div_s),
    .lead_i       (lead_s),
    .gap_i        (gap_s),
    .pol_i        (pol_s),
    .lead_len_o   (lead_len),
    .gap_len_o    (gap_len),
    .first_len_o  (first_len),
    .second_len_o (second_len)
  );

  spi_tim_cnt #(.W(CW)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (cyc_ld),
    .ld_val_i (cyc_val),
    .dec_i    (1'b1),
    .zero_o   (cyc_zero)
  );

  spi_tim_cnt #(.W(LENW)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (bit_ld),
    .ld_val_i (cmd_i[LENW-1:0]),
    .dec_i    (bit_dec),
    .zero_o   (bit_zero)
  );

  // Next-state logic: each state lasts exactly the loaded length in cycles.
  always_comb begin
    st_n    = st_q;
    cyc_ld  = 1'b0;
    cyc_val = '0;
    bit_ld  = 1'b0;
    bit_dec = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_n    = ST_LEAD;
          cyc_ld  = 1'b1;
          cyc_val = lead_len - CW'(1);
          bit_ld  = 1'b1;
        end
      end
      ST_LEAD: begin
        if (cyc_zero) begin
          st_n    = ST_FIRST;
          cyc_ld  = 1'b1;
          cyc_val = first_len - CW'(1);
        end
      end
      ST_FIRST: begin
        if (cyc_zero) begin
          st_n    = ST_SECOND;
          cyc_ld  = 1'b1;
          cyc_val = second_len - CW'(1);
        end
      end
      ST_SECOND: begin
        if (cyc_zero) begin
          cyc_ld = 1'b1;
          if (bit_zero) begin
            st_n    = ST_GAP;
            cyc_val = gap_len - CW'(1);
          end else begin
            st_n    = ST_FIRST;
            cyc_val = first_len - CW'(1);
            bit_dec = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cyc_zero) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_n;
    end
  end

  // Frame settings are captured only when a start is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      pre_q  <= '0;
      div_q  <= '0;
      lead_q <= '0;
      gap_q  <= '0;
    end else if (acc) begin
      pol_q  <= cmd_i[CMD_POL_BIT];
      pha_q  <= cmd_i[CMD_PHA_BIT];
      pre_q  <= pre_s;
      div_q  <= div_s;
      lead_q <= lead_s;
      gap_q  <= gap_s;
    end
  end

  spi_tim_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_q_i      (st_q),
    .st_n_i      (st_n),
    .pol_n_i     (pol_s),
    .pha_i       (pha_q),
    .cyc_zero_i  (cyc_zero),
    .sck_o       (sck_o),
    .sample_o    (sample_o),
    .shift_o     (shift_o),
    .lead_done_o (lead_done_o),
    .gap_done_o  (gap_done_o)
  );

  assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/spi_sck_timer_chk.sv
module spi_sck_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic sck_o,
  input logic sample_o,
  input logic shift_o,
  input logic lead_done_o,
  input logic gap_done_o
);

  // R6: sample and shift belong to opposite edges, never the same cycle
  p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_o, shift_o, lead_done_o, gap_done_o}));

  // R6: every SCK transition inside a frame is announced by a strobe
  p_edge_announced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sck_o != $past(sck_o)) && $past(busy_o)) |-> $past(sample_o || shift_o));

  // R3: strobes only appear while a frame runs
  p_strobe_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o || shift_o || lead_done_o || gap_done_o) |-> busy_o);

  // R3: the end of the lead interval leaves SCK at the idle level
  p_lead_keeps_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lead_done_o |=> $stable(sck_o));

  // R4: busy drops right after the gap strobe
  p_gap_ends_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done_o |=> !busy_o);

  // R8: an idle start is always taken
  p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

endmodule

bind spi_sck_timer spi_sck_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .sck_o       (sck_o),
  .sample_o    (sample_o),
  .shift_o     (shift_o),
  .lead_done_o (lead_done_o),
  .gap_done_o  (gap_done_o)
);

// File: tb/sim_spi_sck_timer.sv
module sim_spi_sck_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] cmd_i;
  logic [23:0] cfg_i;
  logic        busy_o, sck_o, sample_o, shift_o, lead_done_o, gap_done_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  spi_sck_timer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .cfg_i       (cfg_i),
    .busy_o      (busy_o),
    .sck_o       (sck_o),
    .sample_o    (sample_o),
    .shift_o     (shift_o),
    .lead_done_o (lead_done_o),
    .gap_done_o  (gap_done_o)
  );

  // Expected {busy, sck, sample, shift, lead_done, gap_done} in cycle k of a frame.
  function automatic logic [5:0] expect_vec(input int k, input bit pol, input bit pha,
                                            input int pre, input int dv, input int ld,
                                            input int gp, input int nb);
    int per, hi, first, llen, glen, n, j;
    logic le, tr;
    per   = (dv + 2) << pre;
    hi    = per / 2;
    first = pol ? hi : per - hi;
    llen  = (ld + 1) << pre;
    glen  = (gp + 1) << pre;
    n     = nb + 1;
    if (k < llen) return {1'b1, pol, 1'b0, 1'b0, (k == llen - 1), 1'b0};
    if (k < llen + n * per) begin
      j  = (k - llen) % per;
      le = (j == first - 1);
      tr = (j == per - 1);
      return {1'b1, (j < first) ? pol : ~pol, pha ? tr : le, pha ? le : tr, 1'b0, 1'b0};
    end
    if (k < llen + n * per + glen)
      return {1'b1, pol, 1'b0, 1'b0, 1'b0, (k == llen + n * per + glen - 1)};
    return {1'b0, pol, 4'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [31:0] cmd, input logic [23:0] cfg, input bit poke);
    bit pol, pha;
    int pre, dv, ld, gp, nb, per, llen, total, nsamp, nshift;
    logic [5:0] act, exp;
    string tag;
    pol = cmd[31]; pha = cmd[30]; pre = int'(cmd[29:27]); nb = int'(cmd[4:0]);
    dv = int'(cfg[7:0]); gp = int'(cfg[15:8]); ld = int'(cfg[23:16]);
    per   = (dv + 2) << pre;
    llen  = (ld + 1) << pre;
    total = llen + (nb + 1) * per + ((gp + 1) << pre);
    nsamp = 0; nshift = 0;
    @(negedge clk);
    start_i = 1'b1; cmd_i = cmd; cfg_i = cfg;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < total + 2; k++) begin
      act = {busy_o, sck_o, sample_o, shift_o, lead_done_o, gap_done_o};
      exp = expect_vec(k, pol, pha, pre, dv, ld, gp, nb);
      if (poke)                             tag = "R8";
      else if (k < llen)                    tag = "R3";
      else if (k < llen + (nb + 1) * per)   tag = (act[3:2] != exp[3:2]) ? "R6" :
                                                  ((per % 2) == 1) ? "R2" : "R1";
      else if (k < total)                   tag = "R4";
      else                                  tag = "R5";
      check(act == exp, tag, 32'(act), 32'(exp));
      nsamp  += int'(sample_o);
      nshift += int'(shift_o);
      if (poke && k == 1) begin cmd_i = $urandom; cfg_i = 24'($urandom); end
      if (poke && k == 3) start_i = 1'b1;
      if (poke && k == 4) start_i = 1'b0;
      @(negedge clk);
    end
    // R7: strobe totals match the bit count
    check(nsamp == nb + 1 && nshift == nb + 1, "R7", 32'(nsamp), 32'(nb + 1));
  endtask

  function automatic logic [31:0] mk_cmd(input bit pol, input bit pha, input int pre, input int nb);
    return {pol, pha, 3'(pre), 22'd0, 5'(nb)};
  endfunction

  function automatic logic [23:0] mk_cfg(input int ld, input int gp, input int dv);
    return {8'(ld), 8'(gp), 8'(dv)};
  endfunction

  initial begin
    #(20 * 190000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; cfg_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check({busy_o, sck_o, sample_o, shift_o, lead_done_o, gap_done_o} == 6'b0, "R9",
          32'({busy_o, sck_o, sample_o, shift_o, lead_done_o, gap_done_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy_o, sck_o} == 2'b0, "R9", 32'({busy_o, sck_o}), 32'd0);

    // Directed corners
    run_frame(mk_cmd(0, 0, 0, 0),  mk_cfg(0, 0, 0),   1'b0); // fastest, R2 two-cycle period
    run_frame(mk_cmd(0, 0, 0, 2),  mk_cfg(1, 1, 1),   1'b0); // odd period, pol 0
    run_frame(mk_cmd(1, 1, 0, 2),  mk_cfg(1, 2, 1),   1'b0); // odd period, pol 1
    run_frame(mk_cmd(1, 1, 0, 1),  mk_cfg(0, 0, 255), 1'b0); // largest divider
    run_frame(mk_cmd(1, 0, 7, 0),  mk_cfg(2, 0, 1),   1'b0); // largest prescaler
    run_frame(mk_cmd(0, 1, 0, 31), mk_cfg(0, 0, 0),   1'b0); // longest frame
    run_frame(mk_cmd(1, 0, 1, 3),  mk_cfg(0, 0, 0),   1'b1); // R8 ignored start
    run_frame(mk_cmd(0, 1, 0, 0),  mk_cfg(0, 0, 0),   1'b1); // R8 start in gap
    // R5: idle level kept
    repeat (5) @(negedge clk);
    check(sck_o == 1'b0 && busy_o == 1'b0, "R5", 32'({busy_o, sck_o}), 32'd0);

    for (int i = 0; i < 40; i++) begin
      run_frame(mk_cmd($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 8),
                mk_cfg($urandom % 16, $urandom % 16, $urandom % 16), ($urandom % 5) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule